// File: doc/BRIEF.md
# LPDDR2 Power-Up Initialization Sequencer

This block brings a low-power DDR2 SDRAM from power-up to its operating state. After a start request it first emits one-cycle load strobes that tell the surrounding controller to latch its static settings. It then presents a fixed series of memory commands over a valid/ready channel. Each command carries a 2-bit operation code and a 6-bit mode register number. The required power-up pauses are counted in clock cycles, derived from nanosecond parameters and the clock period.

Along the way the sequencer drives two level outputs. The first selects the calibration type the controller should use. The second opens the DRAM input buffers for the window in which the second group of mode register writes is sent. Once the controller has returned to normal mode, the sequencer requests the refresh-interval load and then the temperature-polling configuration load. After that it raises done, which stays high until reset. The mode register data values and the physical interface belong to the surrounding controller.

Top module: `lpddr2_init_seq`

## Requirements
- R1: Out of reset, and until start is sampled high, cmd_valid, cfg_load, zq_short, ibuf_en and done are all low.
- R2: After start, cfg_load pulses for seven consecutive cycles with cfg_sel 0 to 6 in rising order, before the first command is presented. cfg_sel codes are: 0 low-power settings, 1 calibration timing, 2 memory type, 3 configuration, 4 to 6 timing sets, 7 refresh interval, 8 temperature polling. cfg_load is never high while cmd_valid is high.
- R3: The accepted commands are exactly, in order: NOP, acknowledge write, NOP, MRW 63, MRW 10, MRW 1, MRW 2, MRW 3, MRW 16, NOP, MRW 5, MRW 6, MRW 8, MRW 0, NORMAL. cmd_op encodes NOP=0, acknowledge write=1, MRW=2, NORMAL=3, and cmd_mr is 0 for every operation except MRW.
- R4: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_op and cmd_mr hold their values.
- R5: A command is accepted in a cycle where both cmd_valid and cmd_ready are high. Where no pause lies between two commands, the next cmd_valid rises 2 cycles after that acceptance cycle. The only exception is the NOP that follows MRW 16, which rises 3 cycles after.
- R6: Each pause lasts N = max(1, ceil(ns*1000/CLK_PS)) cycles. The next command then rises N+3 cycles after the preceding acceptance. The pauses are: SHORT_NS after the acknowledge write, LONG_NS after the second NOP, and RESET_NS after MRW 63.
- R7: zq_short (0 = reset calibration, 1 = short calibration) is 0 up to and including the cycle that accepts MRW 10, and is 1 from the next cycle until reset.
- R8: ibuf_en is high when the NOP after MRW 16, MRW 5, 6, 8, 0 and NORMAL are accepted. It is low for every earlier command and low once done is high.
- R9: If NORMAL is accepted in cycle a, cfg_load pulses with cfg_sel 7 in cycle a+2 and with cfg_sel 8 in cycle a+3. done is high from cycle a+5.
- R10: done stays high until reset, and a start request after done produces no further load strobe or command.
- R11: A start request while the sequence is running has no effect on the commands, loads or completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the initialization sequence (accepted once after reset) |
| cmd_ready | input | 1 | Controller accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_op | output | 2 | Command operation code |
| cmd_mr | output | 6 | Mode register number for MRW commands |
| cfg_load | output | 1 | One-cycle strobe to latch the setting named by cfg_sel |
| cfg_sel | output | 4 | Which setting to latch |
| zq_short | output | 1 | Calibration type: 0 reset, 1 short |
| ibuf_en | output | 1 | DRAM input buffers open |
| done | output | 1 | Initialization complete |

## Verification
The sequence is run with the controller answering after 0, 1, 2 and 3 cycles of wait. Zero wait exposes the raw spacing between commands. Longer waits expose any drift of the held command and any pause that counts from presentation rather than from acceptance. The design is built with a slow assumed clock period, so each pause rounds up to a distinct, non-integral cycle count (4, 34 and 67); a missing round-up or an exchanged pause shows as a wrong gap. A run peppered with extra start pulses is compared cycle for cycle against an undisturbed run, and a start after completion must leave the outputs silent.

// File: rtl/lpddr2_init_pkg.sv
`timescale 1ns/1ps
// Shared types, the step table and the pause rounding for the LPDDR2
// initialization sequencer. Assumes a single clock domain.
package lpddr2_init_pkg;

    localparam int MR_W    = 6;
    localparam int SEL_W   = 4;
    localparam int STEP_W  = 5;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_ACK_WR = 2'd1,
        OP_MRW    = 2'd2,
        OP_NORMAL = 2'd3
    } cmd_op_e;

    typedef enum logic [2:0] {
        SK_LOAD,
        SK_CMD,
        SK_WAIT,
        SK_IBUF_ON,
        SK_IBUF_OFF,
        SK_FINISH
    } step_kind_e;

    typedef enum logic [1:0] {
        PZ_SHORT,
        PZ_LONG,
        PZ_RESET
    } pause_e;

    localparam logic [SEL_W-1:0] SEL_LOWPWR   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CALTIME  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_MEMTYPE  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_CONFIG   = 4'd3;
    localparam logic [SEL_W-1:0] SEL_TIMING0  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_TIMING1  = 4'd5;
    localparam logic [SEL_W-1:0] SEL_TIMING2  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_REFRESH  = 4'd7;
    localparam logic [SEL_W-1:0] SEL_TEMPPOLL = 4'd8;

    localparam logic [MR_W-1:0] MR_DEVRESET = 6'd63;
    localparam logic [MR_W-1:0] MR_ZQCAL    = 6'd10;

    typedef struct packed {
        step_kind_e            kind;
        cmd_op_e               op;
        logic [MR_W-1:0]       mr;
        pause_e                pause;
        logic [SEL_W-1:0]      sel;
    } step_t;

    // Cycles covering a pause in ns, rounded up, never below one.
    function automatic int unsigned pause_cycles(input int unsigned ns,
                                                 input int unsigned clk_ps);
        longint unsigned num;
        longint unsigned q;
        num = longint'(ns) * 64'd1000;
        q   = (num + longint'(clk_ps) - 64'd1) / longint'(clk_ps);
        if (q < 64'd1) q = 64'd1;
        return int'(q);
    endfunction

    function automatic step_t mk_step(input step_kind_e k, input cmd_op_e o,
                                      input logic [MR_W-1:0] m, input pause_e p,
                                      input logic [SEL_W-1:0] s);
        step_t r;
        r.kind  = k;
        r.op    = o;
        r.mr    = m;
        r.pause = p;
        r.sel   = s;
        return r;
    endfunction

    function automatic step_t ld(input logic [SEL_W-1:0] s);
        return mk_step(SK_LOAD, OP_NOP, '0, PZ_SHORT, s);
    endfunction

    function automatic step_t cmd(input cmd_op_e o, input logic [MR_W-1:0] m);
        return mk_step(SK_CMD, o, m, PZ_SHORT, '0);
    endfunction

    function automatic step_t pz(input pause_e p);
        return mk_step(SK_WAIT, OP_NOP, '0, p, '0);
    endfunction

    // The bring-up order; the order itself is the behaviour.
    function automatic step_t step_at(input logic [STEP_W-1:0] idx);
        case (idx)
            5'd0:  return ld(SEL_LOWPWR);
            5'd1:  return ld(SEL_CALTIME);
            5'd2:  return ld(SEL_MEMTYPE);
            5'd3:  return ld(SEL_CONFIG);
            5'd4:  return ld(SEL_TIMING0);
            5'd5:  return ld(SEL_TIMING1);
            5'd6:  return ld(SEL_TIMING2);
            5'd7:  return cmd(OP_NOP, '0);
            5'd8:  return cmd(OP_ACK_WR, '0);
            5'd9:  return pz(PZ_SHORT);
            5'd10: return cmd(OP_NOP, '0);
            5'd11: return pz(PZ_LONG);
            5'd12: return cmd(OP_MRW, MR_DEVRESET);
            5'd13: return pz(PZ_RESET);
            5'd14: return cmd(OP_MRW, MR_ZQCAL);
            5'd15: return cmd(OP_MRW, 6'd1);
            5'd16: return cmd(OP_MRW, 6'd2);
            5'd17: return cmd(OP_MRW, 6'd3);
            5'd18: return cmd(OP_MRW, 6'd16);
            5'd19: return mk_step(SK_IBUF_ON, OP_NOP, '0, PZ_SHORT, '0);
            5'd20: return cmd(OP_NOP, '0);
            5'd21: return cmd(OP_MRW, 6'd5);
            5'd22: return cmd(OP_MRW, 6'd6);
            5'd23: return cmd(OP_MRW, 6'd8);
            5'd24: return cmd(OP_MRW, 6'd0);
            5'd25: return cmd(OP_NORMAL, '0);
            5'd26: return mk_step(SK_IBUF_OFF, OP_NOP, '0, PZ_SHORT, '0);
            5'd27: return ld(SEL_REFRESH);
            5'd28: return ld(SEL_TEMPPOLL);
            default: return mk_step(SK_FINISH, OP_NOP, '0, PZ_SHORT, '0);
        endcase
    endfunction

endpackage

// File: rtl/lpddr2_step_rom.sv
`timescale 1ns/1ps
// Step decoder: maps the sequencer's step index to the action of that step.
// Purely combinational; indices past the table decode to the finish step.
module lpddr2_step_rom
    import lpddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] idx_i,
    output step_t             step_o
);

    // Look up the current step.
    always_comb begin
        step_o = step_at(idx_i);
    end

endmodule

// File: rtl/lpddr2_pause_timer.sv
`timescale 1ns/1ps
// Pause timer: one down-counter shared by all pauses. A load pulse picks
// the length for the selected pause; expired_o is high in the cycle the
// count reaches one. Assumes each length is at least one cycle.
module lpddr2_pause_timer
    import lpddr2_init_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 1,
    parameter int unsigned LONG_CYC  = 1,
    parameter int unsigned RESET_CYC = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  pause_e sel_i,
    output logic   expired_o
);

    localparam int unsigned MAX_AB  = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int unsigned MAX_CYC = (MAX_AB > RESET_CYC) ? MAX_AB : RESET_CYC;
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] RESET_V = CNT_W'(RESET_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Pick the length of the requested pause.
    always_comb begin
        case (sel_i)
            PZ_LONG:  load_val = LONG_V;
            PZ_RESET: load_val = RESET_V;
            default:  load_val = SHORT_V;
        endcase
    end

    // Load on request, otherwise count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/lpddr2_cmd_port.sv
`timescale 1ns/1ps
// Command port: registers one command at a time and holds it on the
// valid/ready channel until accepted. A new command is taken only while
// no command is pending, so one idle cycle follows each acceptance.
module lpddr2_cmd_port
    import lpddr2_init_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  cmd_op_e         op_i,
    input  logic [MR_W-1:0] mr_i,
    input  logic            ready_i,
    output logic            valid_o,
    output cmd_op_e         op_o,
    output logic [MR_W-1:0] mr_o,
    output logic            accept_o
);

    // Hold the pending command; drop valid on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            op_o    <= OP_NOP;
            mr_o    <= '0;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end else if (issue_i && !valid_o) begin
            valid_o <= 1'b1;
            op_o    <= op_i;
            mr_o    <= mr_i;
        end
    end

    assign accept_o = valid_o && ready_i;

endmodule

// File: rtl/lpddr2_init_seq.sv
`timescale 1ns/1ps
// LPDDR2 initialization sequencer top. Walks the step table once per reset:
// setting loads, commands, pauses and buffer-window changes, then done.
// Assumes CLK_PS is the true clock period; pauses round up to cycles.
module lpddr2_init_seq
    import lpddr2_init_pkg::*;
#(
    parameter int unsigned CLK_PS   = 5000,
    parameter int unsigned SHORT_NS = 100,
    parameter int unsigned LONG_NS  = 200000,
    parameter int unsigned RESET_NS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmd_ready,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic [5:0] cmd_mr,
    output logic       cfg_load,
    output logic [3:0] cfg_sel,
    output logic       zq_short,
    output logic       ibuf_en,
    output logic       done
);

    localparam int unsigned SHORT_CYC = pause_cycles(SHORT_NS, CLK_PS);
    localparam int unsigned LONG_CYC  = pause_cycles(LONG_NS, CLK_PS);
    localparam int unsigned RESET_CYC = pause_cycles(RESET_NS, CLK_PS);

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DONE} phase_e;

    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    logic              armed_q;
    logic              zq_q;
    logic              ibuf_q;
    step_t             cur;
    logic              running;
    logic              advance;
    logic              issue;
    logic              tmr_load;
    logic              tmr_exp;
    logic              cmd_acc;
    cmd_op_e           port_op;

    lpddr2_step_rom u_rom (
        .idx_i  (step_q),
        .step_o (cur)
    );

    lpddr2_pause_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC),
        .RESET_CYC (RESET_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .sel_i     (cur.pause),
        .expired_o (tmr_exp)
    );

    lpddr2_cmd_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue),
        .op_i     (cur.op),
        .mr_i     (cur.mr),
        .ready_i  (cmd_ready),
        .valid_o  (cmd_valid),
        .op_o     (port_op),
        .mr_o     (cmd_mr),
        .accept_o (cmd_acc)
    );

    assign running  = (phase_q == PH_RUN);
    assign issue    = running && (cur.kind == SK_CMD);
    assign tmr_load = running && (cur.kind == SK_WAIT) && !armed_q;
    assign cfg_load = running && (cur.kind == SK_LOAD);
    assign cfg_sel  = cur.sel;
    assign cmd_op   = port_op;
    assign zq_short = zq_q;
    assign ibuf_en  = ibuf_q;
    assign done     = (phase_q == PH_DONE);

    // Decide whether the current step is complete this cycle.
    always_comb begin
        advance = 1'b0;
        if (running) begin
            case (cur.kind)
                SK_LOAD, SK_IBUF_ON, SK_IBUF_OFF: advance = 1'b1;
                SK_CMD:                           advance = cmd_acc;
                SK_WAIT:                          advance = armed_q && tmr_exp;
                default:                          advance = 1'b0;
            endcase
        end
    end

    // Phase and step progression; start is honoured only from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_RUN;
                        step_q  <= '0;
                    end
                end
                PH_RUN: begin
                    if (cur.kind == SK_FINISH) begin
                        phase_q <= PH_DONE;
                    end else if (advance) begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: phase_q <= PH_DONE;
            endcase
        end
    end

    // Mark a pause as started so the timer is loaded exactly once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (tmr_load) begin
            armed_q <= 1'b1;
        end else if (advance) begin
            armed_q <= 1'b0;
        end
    end

    // Switch calibration type to short once the calibration write is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zq_q <= 1'b0;
        end else if (cmd_acc && cur.kind == SK_CMD && cur.op == OP_MRW
                     && cur.mr == MR_ZQCAL) begin
            zq_q <= 1'b1;
        end
    end

    // Open and close the input-buffer window at its two steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf_q <= 1'b0;
        end else if (running && cur.kind == SK_IBUF_ON) begin
            ibuf_q <= 1'b1;
        end else if (running && cur.kind == SK_IBUF_OFF) begin
            ibuf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lpddr2_init_seq_checker.sv
`timescale 1ns/1ps
// Protocol and ordering properties of the sequencer, watched at its ports.
module lpddr2_init_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [5:0] cmd_mr,
    input logic       cfg_load,
    input logic [3:0] cfg_sel,
    input logic       zq_short,
    input logic       ibuf_en,
    input logic       done
);

    assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_mr)));

    assert_load_not_with_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> !cmd_valid);

    assert_sel_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (cfg_sel <= 4'd8));

    assert_zq_after_cal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zq_short) |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd2 && cmd_mr == 6'd10));

    assert_zq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zq_short |=> zq_short);

    assert_ibuf_closed_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ibuf_en);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_done_after_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cfg_load && cfg_sel == 4'd8, 2));

    assert_quiet_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_valid && !cfg_load));

endmodule

bind lpddr2_init_seq lpddr2_init_seq_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_mr    (cmd_mr),
    .cfg_load  (cfg_load),
    .cfg_sel   (cfg_sel),
    .zq_short  (zq_short),
    .ibuf_en   (ibuf_en),
    .done      (done)
);

// File: tb/lpddr2_init_seq_test.sv
`timescale 1ns/1ps
module lpddr2_init_seq_test;

    localparam int CLK_PS_P   = 30000;
    localparam int SHORT_NS_P = 100;
    localparam int LONG_NS_P  = 2000;
    localparam int RESET_NS_P = 1000;

    function automatic int cyc_of(input int ns);
        int q;
        q = (ns * 1000 + CLK_PS_P - 1) / CLK_PS_P;
        return (q < 1) ? 1 : q;
    endfunction

    localparam int N_SHORT = cyc_of(SHORT_NS_P);
    localparam int N_LONG  = cyc_of(LONG_NS_P);
    localparam int N_RESET = cyc_of(RESET_NS_P);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cmd_ready = 1'b0;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [5:0] cmd_mr;
    logic       cfg_load;
    logic [3:0] cfg_sel;
    logic       zq_short;
    logic       ibuf_en;
    logic       done;

    lpddr2_init_seq #(
        .CLK_PS   (CLK_PS_P),
        .SHORT_NS (SHORT_NS_P),
        .LONG_NS  (LONG_NS_P),
        .RESET_NS (RESET_NS_P)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_mr    (cmd_mr),
        .cfg_load  (cfg_load),
        .cfg_sel   (cfg_sel),
        .zq_short  (zq_short),
        .ibuf_en   (ibuf_en),
        .done      (done)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lat = 0;

    int   acc_c [16];
    int   rise_c [16];
    int   acc_op [16];
    int   acc_mr [16];
    logic acc_zq [16];
    logic acc_ib [16];
    int   ld_sel [12];
    int   ld_c [12];
    int   n_acc, n_rise, n_ld, done_c, stab_err, vcnt;
    logic [1:0] h_op;
    logic [5:0] h_mr;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_acc = 0; n_rise = 0; n_ld = 0; done_c = -1; stab_err = 0; vcnt = 0;
    endtask

    // Expected command list (R3).
    function automatic int exp_op(input int i);
        case (i)
            0, 2, 9: return 0;
            1:       return 1;
            14:      return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_mr(input int i);
        case (i)
            3: return 63;  4: return 10;  5: return 1;  6: return 2;
            7: return 3;   8: return 16;  10: return 5; 11: return 6;
            12: return 8;  default: return 0;
        endcase
    endfunction

    // Expected gap from acceptance of command i-1 to rise of command i (R5, R6).
    function automatic int exp_gap(input int i);
        case (i)
            2: return N_SHORT + 3;
            3: return N_LONG + 3;
            4: return N_RESET + 3;
            9: return 3;
            default: return 2;
        endcase
    endfunction

    // Monitor and ready responder, sampling at the falling edge.
    initial begin
        clear_log();
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                cmd_ready = 1'b0;
                vcnt = 0;
            end else begin
                if (cfg_load) begin
                    if (n_ld < 12) begin
                        ld_sel[n_ld] = int'(cfg_sel);
                        ld_c[n_ld] = cyc;
                    end
                    n_ld++;
                end
                if (done && done_c < 0) done_c = cyc;
                if (cmd_valid) begin
                    if (vcnt == 0) begin
                        if (n_rise < 16) rise_c[n_rise] = cyc;
                        n_rise++;
                        h_op = cmd_op;
                        h_mr = cmd_mr;
                    end else if (cmd_op != h_op || cmd_mr != h_mr) begin
                        stab_err++;
                    end
                    if (vcnt >= lat) begin
                        if (n_acc < 16) begin
                            acc_c[n_acc]  = cyc;
                            acc_op[n_acc] = int'(cmd_op);
                            acc_mr[n_acc] = int'(cmd_mr);
                            acc_zq[n_acc] = zq_short;
                            acc_ib[n_acc] = ibuf_en;
                        end
                        n_acc++;
                        cmd_ready = 1'b1;
                        vcnt = 0;
                    end else begin
                        cmd_ready = 1'b0;
                        vcnt++;
                    end
                end else begin
                    cmd_ready = 1'b0;
                    vcnt = 0;
                end
            end
        end
    end

    task automatic run_seq(input int l, input bit poke, output int span);
        int st;
        int t;
        lat = l;
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_log();
        repeat (4) @(negedge clk);
        // R1: quiet after reset and before start
        chk("R1", "valid after reset", int'(cmd_valid), 0);
        chk("R1", "load strobes before start", n_ld, 0);
        chk("R1", "done/zq/ibuf after reset", int'({done, zq_short, ibuf_en}), 0);
        @(negedge clk);
        start = 1'b1;
        st = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: extra start pulses mid-sequence
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (90) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        span = done_c - st;

        chk("R2", "number of load strobes", n_ld, 9);
        if (n_ld >= 9) begin
            for (int i = 0; i < 7; i++) begin
                chk("R2", "early load select", ld_sel[i], i);
                chk("R2", "early load cycle", ld_c[i], ld_c[0] + i);
            end
            if (n_rise > 0)
                chk("R2", "loads precede first command", int'(ld_c[6] < rise_c[0]), 1);
        end
        chk("R3", "number of accepted commands", n_acc, 15);
        chk("R4", "held command changed", stab_err, 0);
        if (n_acc == 15 && n_rise == 15) begin
            for (int i = 0; i < 15; i++) begin
                chk("R3", $sformatf("op of command %0d", i), acc_op[i], exp_op(i));
                chk("R3", $sformatf("mr of command %0d", i), acc_mr[i], exp_mr(i));
                chk("R7", $sformatf("zq type at command %0d", i), int'(acc_zq[i]), (i >= 5) ? 1 : 0);
                chk("R8", $sformatf("ibuf at command %0d", i), int'(acc_ib[i]), (i >= 9) ? 1 : 0);
                chk("R4", $sformatf("accept latency of command %0d", i), acc_c[i] - rise_c[i], l);
            end
            for (int i = 1; i < 15; i++) begin
                if (i >= 2 && i <= 4)
                    chk("R6", $sformatf("pause gap before command %0d", i), rise_c[i] - acc_c[i-1], exp_gap(i));
                else
                    chk("R5", $sformatf("gap before command %0d", i), rise_c[i] - acc_c[i-1], exp_gap(i));
            end
            if (n_ld >= 9) begin
                chk("R9", "refresh load select", ld_sel[7], 7);
                chk("R9", "refresh load cycle", ld_c[7], acc_c[14] + 2);
                chk("R9", "poll load select", ld_sel[8], 8);
                chk("R9", "poll load cycle", ld_c[8], acc_c[14] + 3);
            end
            chk("R9", "done cycle", done_c, acc_c[14] + 5);
        end
        chk("R8", "ibuf closed at done", int'(ibuf_en), 0);
        chk("R7", "zq short at done", int'(zq_short), 1);
    endtask

    initial begin
        int span0;
        int span1;
        int span3;
        int span2;
        int span1p;
        int nl;
        int na;
        run_seq(0, 1'b0, span0);
        run_seq(1, 1'b0, span1);
        run_seq(3, 1'b0, span3);
        run_seq(2, 1'b0, span2);
        run_seq(1, 1'b1, span1p);
        chk("R11", "completion time with extra starts", span1p, span1);
        chk("R5", "completion grows one cycle per wait cycle per command", span1 - span0, 15);
        chk("R5", "completion scales with wait", span3 - span0, 45);
        // R10: start after done is ignored, done holds
        nl = n_ld;
        na = n_rise;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        chk("R10", "loads after late start", n_ld, nl);
        chk("R10", "commands after late start", n_rise, na);
        chk("R10", "done holds", int'(done), 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule